// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt events from up to eleven peripheral sources and presents a single interrupt request to the CPU. Each source delivers a one-cycle pulse that latches a bit in a pending register. The bit stays latched until software acknowledges it. Software also owns an enable register that selects which pending bits may reach the CPU. The CPU line is raised whenever at least one pending bit is also enabled.

Both registers are reached through a plain register bus that carries 16-bit or 32-bit accesses. The pending register sits at window offset 0x70 and the enable register at 0x74. Software acknowledges events by writing the pending register. The written word is ANDed into the latched bits, so a 0 clears a bit and a 1 leaves it as it is. Writing the enable register replaces its contents. If that write exposes a bit that is already pending, the CPU line rises with no new event. By convention, source index 3 carries the DMA controller's completion request.

Top module: `irq_status_mask_ctl`

## Requirements
- R1: Reset, synchronous and active high, clears the pending register, the enable register, `irq_out` and `bus_rdata` to zero.
- R2: A 1 on `src_pulse[i]` in a cycle sets pending bit i at that clock edge. The bit stays set through idle cycles until it is acknowledged. Source index 3 is the DMA completion request and behaves like every other source.
- R3: A write to offset 0x70 sets the pending bits to the old pending bits ANDed with the written data. A written 0 clears a bit and a written 1 keeps it.
- R4: When a source pulse and an acknowledge write that clears the same bit occur in one cycle, the bit is left set.
- R5: A write to offset 0x74 replaces every implemented bit of the enable register with the written data.
- R6: `irq_out` is a register and equals the OR of (pending AND enable) as those registers stand after the same edge. An enable write that uncovers an already pending bit raises `irq_out` at the edge of that write.
- R7: A read (`bus_rd`=1) in one cycle loads `bus_rdata` at that edge with the addressed register's value from before the edge. `bus_rdata` holds its value in cycles without a read.
- R8: Only bits 10:0 are implemented. Read-data bits 31:11 are always zero, and write-data bits 31:11 have no effect.
- R9: `bus_size32`=1 selects a 32-bit access, which must be word aligned. `bus_size32`=0 selects a 16-bit access at byte offset 0 (bits 15:0) or byte offset 2 (bits 31:16, carried on data bits 15:0). A 16-bit access to offset 0x72 or 0x76 therefore changes nothing and reads zero. Misaligned accesses are ignored.
- R10: Accesses to any other offset leave both registers unchanged, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 11 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered CPU interrupt request |

## Verification
The properties take for granted that `src_pulse` bits are plain event levels. They also assume that a read and a write in the same cycle address the same register, and that reset is held for at least one edge. The stimulus applies reads and writes at most once per cycle and drives every input away from the clock edge. It uses only word-aligned or half-word-aligned offsets, except for one deliberate misaligned write that checks the ignore rule.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int BUS_W      = 32;
    localparam int HALF_W     = 16;
    localparam int DEF_SRC_W  = 11;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_PEND_OFS = 'h70;
    localparam int DEF_MASK_OFS = 'h74;
    localparam int DMA_SRC_IDX  = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        LANE_FULL = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2
    } lane_e;

    typedef struct packed {
        logic             wr_pend;
        logic             wr_mask;
        logic             rd_en;
        reg_sel_e         rd_sel;
        lane_e            lane;
        logic [BUS_W-1:0] lane_bits;
        logic [BUS_W-1:0] data_al;
    } access_t;

    function automatic logic [BUS_W-1:0] lane_bits_of(lane_e l);
        case (l)
            LANE_LO: return {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            LANE_HI: return {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            default: return {BUS_W{1'b1}};
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] align_data(lane_e l, logic [BUS_W-1:0] d);
        case (l)
            LANE_LO: return {{HALF_W{1'b0}}, d[HALF_W-1:0]};
            LANE_HI: return {d[HALF_W-1:0], {HALF_W{1'b0}}};
            default: return d;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] narrow_read(lane_e l, logic [BUS_W-1:0] v);
        case (l)
            LANE_LO: return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            LANE_HI: return {{HALF_W{1'b0}}, v[BUS_W-1:HALF_W]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PEND_OFS = DEF_PEND_OFS,
    parameter int MASK_OFS = DEF_MASK_OFS
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_size32,
    input  logic [BUS_W-1:0]  bus_wdata,
    output access_t           acc
);
    localparam logic [ADDR_W-1:0] PEND_A = PEND_OFS[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MASK_A = MASK_OFS[ADDR_W-1:0];

    logic [ADDR_W-1:0] word_addr;
    logic              legal;
    lane_e             lane;
    reg_sel_e          sel;

    always_comb begin
        word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
        if (bus_size32) begin
            legal = (bus_addr[1:0] == 2'b00);
            lane  = LANE_FULL;
        end else begin
            legal = !bus_addr[0];
            lane  = bus_addr[1] ? LANE_HI : LANE_LO;
        end
        if (!legal)                 sel = SEL_NONE;
        else if (word_addr == PEND_A) sel = SEL_PEND;
        else if (word_addr == MASK_A) sel = SEL_MASK;
        else                        sel = SEL_NONE;
    end

    always_comb begin
        acc.wr_pend   = bus_wr && (sel == SEL_PEND);
        acc.wr_mask   = bus_wr && (sel == SEL_MASK);
        acc.rd_en     = bus_rd;
        acc.rd_sel    = sel;
        acc.lane      = lane;
        acc.lane_bits = lane_bits_of(lane);
        acc.data_al   = align_data(lane, bus_wdata);
    end

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_pulse,
    input  logic             ack_en,
    input  logic [SRC_W-1:0] ack_keep,
    output logic [SRC_W-1:0] pend_q,
    output logic [SRC_W-1:0] pend_d
);
    always_comb begin
        pend_d = pend_q;
        if (ack_en) pend_d = pend_d & ack_keep;
        pend_d = pend_d | src_pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|src_pulse) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse))); // R4

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_pulse)) == '0)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_en && src_pulse == '0) |=> $stable(pend_q)); // R3

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SRC_W-1:0] wr_data,
    input  logic [SRC_W-1:0] wr_lane,
    output logic [SRC_W-1:0] mask_q,
    output logic [SRC_W-1:0] mask_d
);
    always_comb begin
        mask_d = mask_q;
        if (wr_en) mask_d = (mask_q & ~wr_lane) | (wr_data & wr_lane);
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask_q)); // R5

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_ctl_pkg::*;
#(
    parameter int SRC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  access_t          acc,
    input  logic [SRC_W-1:0] pend_q,
    input  logic [SRC_W-1:0] mask_q,
    output logic [BUS_W-1:0] rdata_q
);
    logic [BUS_W-1:0] reg_ext;
    logic [BUS_W-1:0] rdata_d;

    always_comb begin
        reg_ext = '0;
        case (acc.rd_sel)
            SEL_PEND: reg_ext[SRC_W-1:0] = pend_q;
            SEL_MASK: reg_ext[SRC_W-1:0] = mask_q;
            default:  reg_ext = '0;
        endcase
        rdata_d = narrow_read(acc.lane, reg_ext);
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata_q <= '0;
        else if (acc.rd_en) rdata_q <= rdata_d;
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !acc.rd_en |=> $stable(rdata_q)); // R7

    generate
        if (SRC_W < BUS_W) begin : g_hi_zero
            AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
                rdata_q[BUS_W-1:SRC_W] == '0); // R8
        end
    endgenerate

endmodule

// File: rtl/irq_status_mask_ctl.sv
module irq_status_mask_ctl
    import irq_ctl_pkg::*;
#(
    parameter int SRC_W    = DEF_SRC_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int PEND_OFS = DEF_PEND_OFS,
    parameter int MASK_OFS = DEF_MASK_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_pulse,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_size32,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_out
);
    access_t          acc;
    logic [SRC_W-1:0] ack_keep;
    logic [SRC_W-1:0] pend_q, pend_d;
    logic [SRC_W-1:0] mask_q, mask_d;
    logic [BUS_W-1:0] keep_full;
    logic             irq_q;

    irq_bus_decode #(
        .ADDR_W  (ADDR_W),
        .PEND_OFS(PEND_OFS),
        .MASK_OFS(MASK_OFS)
    ) u_decode (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size32(bus_size32),
        .bus_wdata (bus_wdata),
        .acc       (acc)
    );

    assign keep_full = acc.data_al | ~acc.lane_bits;
    assign ack_keep  = keep_full[SRC_W-1:0];

    irq_pending_reg #(.SRC_W(SRC_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .src_pulse(src_pulse),
        .ack_en   (acc.wr_pend),
        .ack_keep (ack_keep),
        .pend_q   (pend_q),
        .pend_d   (pend_d)
    );

    irq_mask_reg #(.SRC_W(SRC_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (acc.wr_mask),
        .wr_data(acc.data_al[SRC_W-1:0]),
        .wr_lane(acc.lane_bits[SRC_W-1:0]),
        .mask_q (mask_q),
        .mask_d (mask_d)
    );

    irq_read_port #(.SRC_W(SRC_W)) u_read (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .pend_q (pend_q),
        .mask_q (mask_q),
        .rdata_q(bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_d & mask_d);
    end

    assign irq_out = irq_q;

    AST_IRQ_TRACKS_REGS: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(pend_q & mask_q)); // R6

endmodule

// File: tb/irq_status_mask_ctl_tb.sv
module irq_status_mask_ctl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] src_pulse;
    logic        bus_wr, bus_rd, bus_size32;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_status_mask_ctl u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size32(bus_size32),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [10:0] src;
        logic        wr;
        logic        rd;
        logic        sz32;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        exp_irq;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [0:NV-1] = '{
        '{11'h009, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0,        1'b0, 32'h0},   // R2 pulse bits 0 and 3
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b0, 32'h009}, // R7 read pending
        '{11'h000, 1'b1, 1'b0, 1'b1, 8'h74, 32'hFFFFF008, 1'b1, 32'h0},   // R6 unmask pending, R8
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h74, 32'h0,        1'b1, 32'h008}, // R5 R8 read enable
        '{11'h000, 1'b1, 1'b0, 1'b1, 8'h70, 32'hFFFFFFF7, 1'b0, 32'h0},   // R3 clear bit 3
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b0, 32'h001},
        '{11'h400, 1'b1, 1'b0, 1'b1, 8'h70, 32'h0,        1'b0, 32'h0},   // R4 pulse beats ack
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b0, 32'h400},
        '{11'h000, 1'b1, 1'b0, 1'b0, 8'h76, 32'h0000FFFF, 1'b0, 32'h0},   // R9 upper half write
        '{11'h000, 1'b0, 1'b1, 1'b0, 8'h74, 32'h0,        1'b0, 32'h008},
        '{11'h000, 1'b1, 1'b0, 1'b0, 8'h74, 32'h0000F400, 1'b1, 32'h0},   // R5 16-bit enable
        '{11'h000, 1'b0, 1'b1, 1'b0, 8'h72, 32'h0,        1'b1, 32'h0},   // R9 upper half read
        '{11'h000, 1'b1, 1'b0, 1'b0, 8'h72, 32'h0,        1'b1, 32'h0},   // R9 upper half ack
        '{11'h000, 1'b0, 1'b1, 1'b0, 8'h70, 32'h0,        1'b1, 32'h400},
        '{11'h000, 1'b1, 1'b0, 1'b1, 8'h40, 32'h0,        1'b1, 32'h0},   // R10 other offset
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h40, 32'h0,        1'b1, 32'h0},   // R10 other read
        '{11'h000, 1'b1, 1'b0, 1'b0, 8'h70, 32'h0000FBFF, 1'b0, 32'h0},   // R3 16-bit ack
        '{11'h7FF, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0,        1'b1, 32'h0},   // R2 all sources
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b1, 32'h7FF},
        '{11'h000, 1'b1, 1'b0, 1'b1, 8'h70, 32'hFFFFFFFF, 1'b1, 32'h0},   // R3 ones keep
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b1, 32'h7FF},
        '{11'h000, 1'b1, 1'b0, 1'b1, 8'h74, 32'h0,        1'b0, 32'h0},   // R6 mask all
        '{11'h000, 1'b1, 1'b1, 1'b1, 8'h70, 32'h0,        1'b0, 32'h7FF}, // R7 pre-write value
        '{11'h000, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0,        1'b0, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        src_pulse = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_size32 = 1'b1; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic cyc(input logic [10:0] s, input logic w, input logic r,
                       input logic z, input logic [7:0] a, input logic [31:0] d);
        src_pulse = s; bus_wr = w; bus_rd = r; bus_size32 = z;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle();
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        check("R1 pending after reset", bus_rdata, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h74, 32'h0);
        check("R1 enable after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            src_pulse = VEC[i].src; bus_wr = VEC[i].wr; bus_rd = VEC[i].rd;
            bus_size32 = VEC[i].sz32; bus_addr = VEC[i].addr; bus_wdata = VEC[i].wdata;
            @(negedge clk);
            idle();
            check($sformatf("R6 irq vector %0d", i), {31'h0, irq_out}, {31'h0, VEC[i].exp_irq});
            if (VEC[i].rd)
                check($sformatf("R7 rdata vector %0d", i), bus_rdata, VEC[i].exp_rd);
        end

        // R2: bit 5 remains latched across idle cycles, DMA bit 3 joins it
        cyc(11'h020, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
        repeat (5) @(negedge clk);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        check("R2 sticky bit", bus_rdata, 32'h020);
        cyc(11'h008, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        check("R2 DMA source bit", bus_rdata, 32'h028);

        // R8: all-ones enable write keeps only implemented bits
        cyc(11'h0, 1'b1, 1'b0, 1'b1, 8'h74, 32'hFFFFFFFF);
        check("R6 irq on unmask", {31'h0, irq_out}, 32'h1);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h74, 32'h0);
        check("R8 enable width", bus_rdata, 32'h7FF);

        // R9: misaligned 32-bit write is ignored
        cyc(11'h0, 1'b1, 1'b0, 1'b1, 8'h75, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h74, 32'h0);
        check("R9 misaligned ignored", bus_rdata, 32'h7FF);

        // R3: acknowledge bits 3 and 5, line drops
        cyc(11'h0, 1'b1, 1'b0, 1'b1, 8'h70, 32'hFFFFFFD7);
        check("R3 ack drops irq", {31'h0, irq_out}, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        check("R3 pending after ack", bus_rdata, 32'h0);

        // R1: reset in the middle of activity
        cyc(11'h001, 1'b0, 1'b0, 1'b1, 8'h00, 32'h0);
        check("R6 irq before reset", {31'h0, irq_out}, 32'h1);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 irq cleared", {31'h0, irq_out}, 32'h0);
        check("R1 rdata cleared", bus_rdata, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h70, 32'h0);
        check("R1 pending cleared", bus_rdata, 32'h0);
        cyc(11'h0, 1'b0, 1'b1, 1'b1, 8'h74, 32'h0);
        check("R1 enable cleared", bus_rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule